// File: doc/BRIEF.md
# Packet Stream Receive Checker

This block sits on the receive side of a link that carries 80-bit packets, one packet per cycle in which `in_valid` is high. Each packet is five 16-bit words. The lowest word is a start word that holds the packet type, a direction flag and a channel number. The four upper words are field words. The block decodes every start word and follows a transfer from its header packet to its end-of-buffer packets and its termination packet. Inside a transfer it counts data packets and keeps a 16-bit running checksum of their field words.

When an end-of-buffer packet arrives, the block compares its own count, checksum and buffer number with the values the packet carries. Each mismatch sets a fixed bit in a 32-bit error word. That word is sticky and returns to zero at the next header. Illegal packets are dropped without any trace. Data packets that arrive outside a transfer are dropped and flagged. Every other packet goes to the output unchanged, one cycle later.

Top module: `pktchk_top`

## Requirements
- R1: A packet is laid out with the start word in bits 15:0 and field word k (k = 0..3) in bits 16(k+1)+15 : 16(k+1). The start word carries the type in bits 2:0, the direction in bit 3 and the channel in bits 5:4. Every accepted packet appears bit for bit on `out_pkt` with `out_valid` high in the cycle after it is presented.
- R2: A packet of type 7 (illegal) is not forwarded. It changes neither the data count, the checksum, the buffer number nor the error word.
- R3: A header packet (type 1) is forwarded. It clears the error word, the data count and the checksum, and it opens a transfer.
- R4: A data packet (type 0) inside a transfer is forwarded. It raises the data count by one and adds its four field words to the checksum, modulo 65536.
- R5: At an end-of-buffer packet (type 2), error bit 2 is set if field 2 differs from the data count.
- R6: At an end-of-buffer packet, error bit 3 is set if field 0 differs from the checksum.
- R7: At an end-of-buffer packet, error bit 5 is set if field 3 differs from the internal buffer number. That number is 0 after reset and rises by one, modulo 65536, after every end-of-buffer packet. The same packet also clears the data count and the checksum.
- R8: A data packet that arrives after reset or after a termination packet (type 3), before the next header, is dropped and sets error bit 2.
- R9: Error bits stay set until the next header. Only bits 2, 3 and 5 can ever be set.
- R10: While reset is held, `out_valid` is low and the error word is zero. Types 4, 5 and 6 are forwarded and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A packet is presented this cycle |
| in_pkt | input | 80 | Incoming packet (start word plus four field words) |
| out_valid | output | 1 | Forwarded packet valid |
| out_pkt | output | 80 | Forwarded packet |
| err_word | output | 32 | Sticky error flags of the current transfer |

## Verification
Each result has a fixed latency. The forwarded packet, its valid flag and any change to the error word all appear exactly one clock edge after the packet is presented, because each passes through a single register stage. The bench drives a packet on a falling edge, removes it on the next falling edge and samples all outputs at that same falling edge. Every expectation is therefore compared in the one cycle that carries the packet's result, and the idle cycle after it separates it from the next packet.

// File: rtl/pktchk_pkg.sv
package pktchk_pkg;

    localparam int WORD_W     = 16;
    localparam int NUM_FIELDS = 4;
    localparam int PKT_W      = WORD_W * (NUM_FIELDS + 1);
    localparam int ERR_W      = 32;
    localparam int TYPE_W     = 3;
    localparam int CHAN_W     = 2;

    localparam int ERR_COUNT_BIT = 2;
    localparam int ERR_SUM_BIT   = 3;
    localparam int ERR_BUF_BIT   = 5;

    localparam logic [ERR_W-1:0] ERR_USED_MASK =
        (ERR_W'(1) << ERR_COUNT_BIT) | (ERR_W'(1) << ERR_SUM_BIT) | (ERR_W'(1) << ERR_BUF_BIT);

    localparam int EOB_SUM_FIELD = 0;
    localparam int EOB_CNT_FIELD = 2;
    localparam int EOB_BUF_FIELD = 3;

    typedef enum logic [TYPE_W-1:0] {
        PT_DATA = 3'd0,
        PT_HDR  = 3'd1,
        PT_EOB  = 3'd2,
        PT_TERM = 3'd3,
        PT_EXT  = 3'd4,
        PT_ACK  = 3'd5,
        PT_SIG  = 3'd6,
        PT_ILL  = 3'd7
    } pkt_type_e;

    typedef logic [NUM_FIELDS-1:0][WORD_W-1:0] fields_t;

    typedef struct packed {
        pkt_type_e          ptype;
        logic               reply;
        logic [CHAN_W-1:0]  chan;
        fields_t            field;
    } pkt_info_t;

    function automatic logic [WORD_W-1:0] field_sum(input fields_t f);
        logic [WORD_W-1:0] s;
        s = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            s = s + f[k];
        end
        return s;
    endfunction

endpackage

// File: rtl/pkt_decode.sv
module pkt_decode
    import pktchk_pkg::*;
(
    input  logic [PKT_W-1:0] pkt,
    output pkt_info_t        info
);

    always_comb begin
        info.ptype = pkt_type_e'(pkt[TYPE_W-1:0]);
        info.reply = pkt[TYPE_W];
        info.chan  = pkt[TYPE_W+1 +: CHAN_W];
    end

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        assign info.field[k] = pkt[WORD_W*(k+1) +: WORD_W];
    end

endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
    import pktchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  pkt_info_t        info,
    output logic             accept,
    output logic [ERR_W-1:0] err_word
);

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic              in_xfer_q;
    logic [WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] buf_q;
    logic [ERR_W-1:0]  err_q;
    logic [ERR_W-1:0]  eob_err;
    logic              is_data;
    logic              orphan;

    always_comb begin
        is_data = in_valid && (info.ptype == PT_DATA);
        orphan  = is_data && !in_xfer_q;
        accept  = in_valid && (info.ptype != PT_ILL) && !orphan;
        eob_err = '0;
        eob_err[ERR_COUNT_BIT] = (info.field[EOB_CNT_FIELD] != cnt_q);
        eob_err[ERR_SUM_BIT]   = (info.field[EOB_SUM_FIELD] != sum_q);
        eob_err[ERR_BUF_BIT]   = (info.field[EOB_BUF_FIELD] != buf_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_xfer_q <= 1'b0;
            cnt_q     <= '0;
            sum_q     <= '0;
            buf_q     <= '0;
            err_q     <= '0;
        end else if (in_valid) begin
            case (info.ptype)
                PT_HDR: begin
                    err_q     <= '0;
                    cnt_q     <= '0;
                    sum_q     <= '0;
                    in_xfer_q <= 1'b1;
                end
                PT_DATA: begin
                    if (in_xfer_q) begin
                        cnt_q <= cnt_q + ONE;
                        sum_q <= sum_q + field_sum(info.field);
                    end else begin
                        err_q[ERR_COUNT_BIT] <= 1'b1;
                    end
                end
                PT_EOB: begin
                    err_q <= err_q | eob_err;
                    cnt_q <= '0;
                    sum_q <= '0;
                    buf_q <= buf_q + ONE;
                end
                PT_TERM: begin
                    in_xfer_q <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    assign err_word = err_q;

    assert_hdr_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.ptype == PT_HDR) |=> (err_word == '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && info.ptype == PT_HDR) |=> ((err_word & $past(err_word)) == $past(err_word)));

    assert_used_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (err_word & ~ERR_USED_MASK) == '0);

    assert_buf_step_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.ptype == PT_EOB) |=> (buf_q == $past(buf_q) + ONE));

    assert_orphan_flag_R8: assert property (@(posedge clk) disable iff (rst)
        orphan |=> err_word[ERR_COUNT_BIT]);

    assert_illegal_inert_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.ptype == PT_ILL) |=>
            ($stable(cnt_q) && $stable(sum_q) && $stable(buf_q) && $stable(err_q)));

endmodule

// File: rtl/pkt_forward.sv
module pkt_forward
    import pktchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    output logic [PKT_W-1:0] out_pkt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pkt   <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_pkt <= in_pkt;
            end
        end
    end

    assert_forward_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && out_pkt == $past(in_pkt)));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

endmodule

// File: rtl/pktchk_top.sv
module pktchk_top
    import pktchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [79:0]      in_pkt,
    output logic             out_valid,
    output logic [79:0]      out_pkt,
    output logic [31:0]      err_word
);

    pkt_info_t info;
    logic      accept;

    pkt_decode u_decode (
        .pkt  (in_pkt),
        .info (info)
    );

    xfer_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .info     (info),
        .accept   (accept),
        .err_word (err_word)
    );

    pkt_forward u_fwd (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .in_pkt    (in_pkt),
        .out_valid (out_valid),
        .out_pkt   (out_pkt)
    );

    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && err_word == '0));

endmodule

// File: tb/tb_pktchk_top.sv
module tb_pktchk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [79:0] in_pkt = '0;
    logic        out_valid;
    logic [79:0] out_pkt;
    logic [31:0] err_word;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [15:0] m_cnt, m_sum, m_buf;
    logic        m_xfer;
    logic [31:0] m_err;

    always #5 clk = ~clk;

    pktchk_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_pkt(out_pkt), .err_word(err_word)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] t, input logic rp, input logic [1:0] ch,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] c, input logic [15:0] d, input string req);
        logic [79:0] p;
        logic        exp_v;
        p = {d, c, b, a, 10'h2A5, ch, rp, t};
        exp_v = 1'b1;
        case (t)
            3'd7: exp_v = 1'b0;
            3'd1: begin m_err = '0; m_cnt = '0; m_sum = '0; m_xfer = 1'b1; end
            3'd0: begin
                if (m_xfer) begin
                    m_cnt = m_cnt + 16'd1;
                    m_sum = m_sum + a + b + c + d;
                end else begin
                    m_err[2] = 1'b1;
                    exp_v = 1'b0;
                end
            end
            3'd2: begin
                if (c != m_cnt) m_err[2] = 1'b1;
                if (a != m_sum) m_err[3] = 1'b1;
                if (d != m_buf) m_err[5] = 1'b1;
                m_buf = m_buf + 16'd1;
                m_cnt = '0;
                m_sum = '0;
            end
            3'd3: m_xfer = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        in_valid = 1'b1;
        in_pkt   = p;
        @(negedge clk);
        in_valid = 1'b0;
        in_pkt   = '0;
        chk(out_valid == exp_v, {req, " valid"}, {79'd0, out_valid}, {79'd0, exp_v});
        if (exp_v) chk(out_pkt == p, {req, " R1 packet"}, out_pkt, p);
        chk(err_word == m_err, {req, " err"}, {48'd0, err_word}, {48'd0, m_err});
    endtask

    // One buffer: header, n data packets, end of buffer with selectable wrong fields
    task automatic run_buffer(input int n, input int mask, input logic rp, input logic [1:0] ch);
        logic [15:0] s;
        logic [15:0] w [4];
        logic [31:0] e;
        s = '0;
        send(3'd1, rp, ch, 16'h1234, 16'h00AB, 16'h0, 16'h0039, "R3 header");
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 4; k++) w[k] = 16'((n * 4099 + i * 771 + k * 16383 + mask * 97) & 16'hFFFF);
            s = s + w[0] + w[1] + w[2] + w[3];
            send(3'd0, rp, ch, w[0], w[1], w[2], w[3], "R4 data");
        end
        e = '0;
        if (mask[0]) e[2] = 1'b1;
        if (mask[1]) e[3] = 1'b1;
        if (mask[2]) e[5] = 1'b1;
        send(3'd2, rp, ch, s + (mask[1] ? 16'd1 : 16'd0), 16'h0,
             16'(n) + (mask[0] ? 16'd1 : 16'd0), m_buf + (mask[2] ? 16'd3 : 16'd0), "R5 R6 R7 eob");
        chk(err_word == e, "R5 R6 R7 error bits 2/3/5", {48'd0, err_word}, {48'd0, e});
    endtask

    initial begin
        m_cnt = '0; m_sum = '0; m_buf = '0; m_xfer = 1'b0; m_err = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && err_word == 32'd0, "R10 reset state", {47'd0, out_valid, err_word}, 80'd0);
        rst = 1'b0;
        @(negedge clk);

        // R8: data before any header
        send(3'd0, 1'b0, 2'd1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R8 orphan data");
        chk(err_word[2] == 1'b1, "R8 orphan flag", {79'd0, err_word[2]}, 80'd1);

        // Exhaustive sweep of lengths and error combinations
        for (int n = 0; n < 6; n++) begin
            for (int mask = 0; mask < 8; mask++) begin
                run_buffer(n, mask, 1'(mask), 2'(n));
            end
        end

        // R2: illegal packet leaves count, checksum and errors untouched
        send(3'd1, 1'b1, 2'd2, 16'h0, 16'h0, 16'h0, 16'h0, "R3 header");
        send(3'd0, 1'b1, 2'd2, 16'h0010, 16'h0020, 16'h0030, 16'h0040, "R4 data");
        send(3'd7, 1'b1, 2'd2, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R2 illegal");
        send(3'd2, 1'b1, 2'd2, 16'h00A0, 16'h0, 16'd1, m_buf, "R2 eob after illegal");
        chk(err_word == 32'd0, "R2 illegal ignored", {48'd0, err_word}, 80'd0);

        // R4: checksum wraps modulo 65536
        send(3'd1, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R3 header");
        send(3'd0, 1'b0, 2'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R4 data");
        send(3'd0, 1'b0, 2'd0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0005, "R4 data");
        send(3'd2, 1'b0, 2'd0, 16'h0001, 16'h0, 16'd2, m_buf, "R4 wrap eob");
        chk(err_word == 32'd0, "R4 checksum wrap", {48'd0, err_word}, 80'd0);

        // R9: bit stays set across a later clean buffer; types 4..6 forwarded inertly
        send(3'd0, 1'b0, 2'd0, 16'd1, 16'd2, 16'd3, 16'd4, "R4 data");
        send(3'd2, 1'b0, 2'd0, 16'd99, 16'h0, 16'd1, m_buf, "R6 bad sum");
        send(3'd4, 1'b0, 2'd3, 16'd5, 16'd6, 16'd7, 16'd8, "R10 ext");
        send(3'd5, 1'b1, 2'd3, 16'd5, 16'd6, 16'd7, 16'd8, "R10 ack");
        send(3'd6, 1'b0, 2'd1, 16'd5, 16'd6, 16'd7, 16'd8, "R10 sig");
        send(3'd2, 1'b0, 2'd0, 16'd0, 16'h0, 16'd0, m_buf, "R9 clean eob");
        chk(err_word == 32'h8, "R9 sticky bit 3", {48'd0, err_word}, 80'h8);

        // R8: data after termination
        send(3'd3, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R8 termination");
        send(3'd0, 1'b0, 2'd0, 16'd1, 16'd1, 16'd1, 16'd1, "R8 data after term");
        chk(err_word == 32'hC, "R8 after term", {48'd0, err_word}, 80'hC);
        send(3'd1, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R3 header clears");
        chk(err_word == 32'd0, "R3 clear", {48'd0, err_word}, 80'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule